// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a processor's memory-mapped bus and the bus behind it. It gives every single bit of two backing regions an address of its own inside a 32 MiB alias window. An upstream access that lands in an alias window is converted into a downstream access of the same size (byte, halfword or word) to a remapped backing address. A read of an alias address returns the selected bit. A write to an alias address sets or clears only that bit through a locked read-modify-write.

Addresses outside both windows are forwarded to the downstream bus unchanged. The bridge handles one request at a time. Upstream ready stays low from acceptance until the last downstream beat of that request completes. The default windows map alias base 0x2200_0000 onto backing base 0x2000_0000, and alias base 0x4200_0000 onto backing base 0x4000_0000.

Top module: `bitband_bridge`

## Requirements
- R1: An address lies in a window when it falls within [alias base, alias base + 0x0200_0000). For the default windows, 0x2200_0000–0x23FF_FFFF maps to backing base 0x2000_0000 and 0x4200_0000–0x43FF_FFFF maps to backing base 0x4000_0000. Any other address, including 0x21FF_FFFC and 0x2400_0000, is not aliased.
- R2: For an aliased access with window offset `off` (address minus alias base), the downstream address is the backing base ORed with `off >> 5`. Bit 0 is cleared for halfwords, and bits 1:0 are cleared for words.
- R3: The size code is 0 for byte, 1 for halfword and 2 for word. The selected bit number is `off >> 2` modulo 8, 16 or 32 respectively. Bit k counts from bit 0 of the little-endian unit, where the byte at the lowest address holds bits 7:0. Data on both buses is right-justified.
- R4: An aliased read issues exactly one unlocked downstream read. It returns the selected bit in bit 0 of `up_rdata`, with all other bits zero.
- R5: An aliased write uses only bit 0 of `up_wdata`. It sets the selected bit when that bit is 1 and clears it when that bit is 0. Every other bit of the backing unit keeps its value.
- R6: An aliased write issues a downstream read and then a write-back of the same address and size. `dn_lock` is high on both beats and low whenever `dn_valid` is low.
- R7: `up_ready` falls in the cycle after a request is accepted. It returns high together with a one-cycle `up_done` pulse when the request completes.
- R8: A non-aliased access issues one unlocked downstream access with the same address, size, direction and write data. A non-aliased read returns the downstream read data unchanged.
- R9: Synchronous reset returns the bridge to idle: `up_ready` high, `dn_valid`, `dn_lock` and `up_done` low. Any in-flight request is dropped without a write-back.
- R10: While `dn_valid` is high and `dn_done` is low, the downstream request fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request present |
| up_ready | output | 1 | Bridge idle and able to accept |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word |
| up_addr | input | 32 | Upstream byte address |
| up_wdata | input | 32 | Upstream write data, right-justified |
| up_done | output | 1 | One-cycle completion pulse |
| up_rdata | output | 32 | Read result, valid with up_done |
| dn_valid | output | 1 | Downstream request active |
| dn_lock | output | 1 | Locked read-modify-write in progress |
| dn_write | output | 1 | Downstream direction |
| dn_size | output | 2 | Downstream size code |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data, right-justified |
| dn_done | input | 1 | Downstream beat complete |
| dn_rdata | input | 32 | Downstream read data, valid with dn_done |

## Verification
A corrupted captured bit number or size shows up as a wrong bit at `up_rdata`, or as a changed neighbour bit in backing memory, on the same access. A mis-decoded window shows up as a passthrough or an alias in the downstream beat that belongs to that access. A state machine stuck in the wrong phase shows up as a missing or extra downstream beat, a lock at the wrong level, or `up_ready` failing to return within the latency of one or two downstream beats. The mid-flight reset case shows whether a stale write-back survives reset.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } bb_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BIT_RD,
    ST_RMW_RD,
    ST_RMW_WR,
    ST_PASS
  } bb_state_e;
endpackage

// File: rtl/bb_win_decode.sv
module bb_win_decode
  import bb_pkg::*;
#(
  parameter int AW = 32,
  parameter int NUM_WIN = 2,
  parameter int WIN_BITS = 25,
  parameter logic [NUM_WIN*AW-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*AW-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [AW-1:0] addr,
  input  bb_size_e      size,
  output logic          hit,
  output logic [AW-1:0] back_addr,
  output logic [4:0]    bit_idx
);
  localparam int UNIT_SHIFT = 5;
  localparam int PAD = AW - WIN_BITS + UNIT_SHIFT;

  logic [WIN_BITS-1:0] off;
  logic [NUM_WIN-1:0]  hit_v;
  logic [AW-1:0]       cand [NUM_WIN];
  logic [AW-1:0]       raw;

  assign off = addr[WIN_BITS-1:0];

  genvar g;
  generate
    for (g = 0; g < NUM_WIN; g++) begin : g_win
      assign hit_v[g] = (addr[AW-1:WIN_BITS] == ALIAS_BASES[g*AW+WIN_BITS +: AW-WIN_BITS]);
      assign cand[g]  = BACK_BASES[g*AW +: AW] |
                        {{PAD{1'b0}}, off[WIN_BITS-1:UNIT_SHIFT]};
    end
  endgenerate

  always_comb begin
    raw = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit_v[i]) raw = cand[i];
    end
    hit = |hit_v;
  end

  always_comb begin
    case (size)
      SZ_BYTE: begin
        back_addr = raw;
        bit_idx   = {2'b00, off[4:2]};
      end
      SZ_HALF: begin
        back_addr = {raw[AW-1:1], 1'b0};
        bit_idx   = {1'b0, off[5:2]};
      end
      default: begin
        back_addr = {raw[AW-1:2], 2'b00};
        bit_idx   = off[6:2];
      end
    endcase
  end
endmodule

// File: rtl/bb_bitop.sv
module bb_bitop
  import bb_pkg::*;
#(
  parameter int DW = 32,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  bb_size_e           size,
  input  logic [4:0]         bit_idx,
  input  logic [DW-1:0]      rd_data,
  input  logic               set_val,
  output logic               bit_val,
  output logic [DW-1:0]      wr_data
);
  logic [DW-1:0] raw_mask;
  logic [DW-1:0] mask;
  logic [DW-1:0] unit_mask;

  assign raw_mask = {{(DW-1){1'b0}}, 1'b1} << bit_idx;

  generate
    if (BIG_ENDIAN) begin : g_be
      always_comb begin
        case (size)
          SZ_BYTE: mask = raw_mask;
          SZ_HALF: mask = {{(DW-16){1'b0}}, raw_mask[7:0], raw_mask[15:8]};
          default: mask = {raw_mask[7:0], raw_mask[15:8], raw_mask[23:16], raw_mask[31:24]};
        endcase
      end
    end else begin : g_le
      assign mask = raw_mask;
    end
  endgenerate

  always_comb begin
    case (size)
      SZ_BYTE: unit_mask = {{(DW-8){1'b0}}, 8'hFF};
      SZ_HALF: unit_mask = {{(DW-16){1'b0}}, 16'hFFFF};
      default: unit_mask = '1;
    endcase
  end

  assign bit_val = |(rd_data & mask);
  assign wr_data = (set_val ? (rd_data | mask) : (rd_data & ~mask)) & unit_mask;
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NUM_WIN = 2,
  parameter int WIN_BITS = 25,
  parameter logic [NUM_WIN*AW-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*AW-1:0] BACK_BASES  = {32'h4000_0000, 32'h2000_0000},
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic          up_write,
  input  logic [1:0]    up_size,
  input  logic [AW-1:0] up_addr,
  input  logic [DW-1:0] up_wdata,
  output logic          up_done,
  output logic [DW-1:0] up_rdata,
  output logic          dn_valid,
  output logic          dn_lock,
  output logic          dn_write,
  output logic [1:0]    dn_size,
  output logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_done,
  input  logic [DW-1:0] dn_rdata
);
  bb_state_e     state;
  logic [4:0]    cur_idx;
  logic          cur_set;
  logic          dec_hit;
  logic [AW-1:0] dec_addr;
  logic [4:0]    dec_idx;
  logic          sel_bit;
  logic [DW-1:0] merged;
  logic          finish;
  logic          accept;

  bb_win_decode #(
    .AW(AW), .NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS),
    .ALIAS_BASES(ALIAS_BASES), .BACK_BASES(BACK_BASES)
  ) u_dec (
    .addr(up_addr),
    .size(bb_size_e'(up_size)),
    .hit(dec_hit),
    .back_addr(dec_addr),
    .bit_idx(dec_idx)
  );

  bb_bitop #(.DW(DW), .BIG_ENDIAN(BIG_ENDIAN)) u_bitop (
    .size(bb_size_e'(dn_size)),
    .bit_idx(cur_idx),
    .rd_data(dn_rdata),
    .set_val(cur_set),
    .bit_val(sel_bit),
    .wr_data(merged)
  );

  assign accept = (state == ST_IDLE) && up_valid && up_ready;

  always_comb begin
    finish = 1'b0;
    if (dn_done) begin
      case (state)
        ST_BIT_RD, ST_RMW_WR, ST_PASS: finish = 1'b1;
        default: finish = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      up_ready <= 1'b1;
      up_done  <= 1'b0;
      up_rdata <= '0;
      dn_valid <= 1'b0;
      dn_lock  <= 1'b0;
      dn_write <= 1'b0;
      dn_size  <= 2'b00;
      dn_addr  <= '0;
      dn_wdata <= '0;
      cur_idx  <= '0;
      cur_set  <= 1'b0;
    end else begin
      up_done <= 1'b0;
      if (accept) begin
        up_ready <= 1'b0;
        dn_valid <= 1'b1;
        dn_size  <= up_size;
        cur_idx  <= dec_idx;
        cur_set  <= up_wdata[0];
        if (dec_hit) begin
          dn_addr  <= dec_addr;
          dn_write <= 1'b0;
          dn_wdata <= '0;
          dn_lock  <= up_write;
          state    <= up_write ? ST_RMW_RD : ST_BIT_RD;
        end else begin
          dn_addr  <= up_addr;
          dn_write <= up_write;
          dn_wdata <= up_wdata;
          dn_lock  <= 1'b0;
          state    <= ST_PASS;
        end
      end else if (state == ST_RMW_RD && dn_done) begin
        dn_write <= 1'b1;
        dn_wdata <= merged;
        state    <= ST_RMW_WR;
      end else if (finish) begin
        case (state)
          ST_BIT_RD: up_rdata <= {{(DW-1){1'b0}}, sel_bit};
          ST_PASS:   up_rdata <= dn_write ? '0 : dn_rdata;
          default:   up_rdata <= '0;
        endcase
        dn_valid <= 1'b0;
        dn_lock  <= 1'b0;
        up_ready <= 1'b1;
        up_done  <= 1'b1;
        state    <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          up_valid,
  input logic          up_ready,
  input logic          up_done,
  input logic          dn_valid,
  input logic          dn_lock,
  input logic          dn_write,
  input logic [1:0]    dn_size,
  input logic [AW-1:0] dn_addr,
  input logic [DW-1:0] dn_wdata,
  input logic          dn_done
);
  // R7
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_ready) |=> !up_ready);

  // R7
  done_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
    up_done |-> up_ready);

  // R6
  locked_read_then_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && dn_done && dn_lock && !dn_write) |=>
    (dn_valid && dn_write && dn_lock && $stable(dn_addr) && $stable(dn_size)));

  // R6
  wb_releases_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && dn_done && dn_write && dn_lock) |=> (!dn_lock && !dn_valid));

  // R6
  lock_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    dn_lock |-> dn_valid);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_done) |=> (dn_valid && $stable(dn_addr) && $stable(dn_write) &&
                                $stable(dn_size) && $stable(dn_wdata) && $stable(dn_lock)));

  // R9
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (up_ready && !dn_valid && !dn_lock && !up_done));
endmodule

bind bitband_bridge bitband_bridge_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready), .up_done(up_done),
  .dn_valid(dn_valid), .dn_lock(dn_lock), .dn_write(dn_write), .dn_size(dn_size),
  .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_done(dn_done)
);

// File: tb/bitband_bridge_tb.sv
module bitband_bridge_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        up_valid = 1'b0, up_write = 1'b0;
  logic [1:0]  up_size = 2'b00;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic        up_ready, up_done;
  logic [31:0] up_rdata;
  logic        dn_valid, dn_lock, dn_write;
  logic [1:0]  dn_size;
  logic [31:0] dn_addr, dn_wdata;
  logic        dn_done = 1'b0;
  logic [31:0] dn_rdata = '0;

  bitband_bridge u_dut (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
    .up_size(up_size), .up_addr(up_addr), .up_wdata(up_wdata), .up_done(up_done),
    .up_rdata(up_rdata), .dn_valid(dn_valid), .dn_lock(dn_lock), .dn_write(dn_write),
    .dn_size(dn_size), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_done(dn_done),
    .dn_rdata(dn_rdata)
  );

  int total = 0, bad = 0, lat = 1, cnt = 0;
  logic [7:0] mem [bit [31:0]];
  logic [7:0] ref_mem [bit [31:0]];
  typedef struct { logic wr; logic [31:0] addr; logic [1:0] size; logic lock; logic [31:0] wdata; } txn_t;
  txn_t log_q[$];

  function automatic logic [7:0] mem_rd(bit [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] ref_rd(bit [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction
  function automatic int nbytes(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  // downstream memory model
  always @(negedge clk) begin
    if (rst) begin
      dn_done = 1'b0; cnt = lat;
    end else if (dn_done) begin
      dn_done = 1'b0; cnt = lat;
    end else if (dn_valid) begin
      if (cnt > 0) cnt--;
      else begin
        log_q.push_back('{dn_write, dn_addr, dn_size, dn_lock, dn_wdata});
        if (dn_write) begin
          for (int i = 0; i < nbytes(dn_size); i++) mem[dn_addr + i] = dn_wdata[8*i +: 8];
        end else begin
          logic [31:0] v;
          v = '0;
          for (int i = 0; i < nbytes(dn_size); i++) v[8*i +: 8] = mem_rd(dn_addr + i);
          dn_rdata = v;
        end
        dn_done = 1'b1;
      end
    end
  end

  task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, input string req);
    bit hit; logic [31:0] base, off, baddr, old, nv, exp_rd;
    int nb, bitn, guard;
    txn_t exp_q[$];
    nb = nbytes(sz); hit = 1'b0; base = '0; off = '0;
    if (a >= 32'h2200_0000 && a < 32'h2400_0000) begin hit = 1; base = 32'h2000_0000; off = a - 32'h2200_0000; end
    else if (a >= 32'h4200_0000 && a < 32'h4400_0000) begin hit = 1; base = 32'h4000_0000; off = a - 32'h4200_0000; end
    if (hit) begin
      baddr = base + off / 32;
      baddr = baddr - (baddr % nb);
      bitn  = int'((off / 4) % (8 * nb));
    end else begin
      baddr = a; bitn = 0;
    end
    old = '0;
    for (int i = 0; i < nb; i++) old[8*i +: 8] = ref_rd(baddr + i);
    if (hit) begin
      exp_rd = {31'b0, old[bitn]};
      nv = old; nv[bitn] = wd[0];
      if (wr) begin
        exp_q.push_back('{1'b0, baddr, sz, 1'b1, 32'h0});
        exp_q.push_back('{1'b1, baddr, sz, 1'b1, nv});
      end else exp_q.push_back('{1'b0, baddr, sz, 1'b0, 32'h0});
    end else begin
      exp_rd = old; nv = wd;
      exp_q.push_back('{wr, a, sz, 1'b0, wd});
    end
    if (wr) for (int i = 0; i < nb; i++) ref_mem[baddr + i] = nv[8*i +: 8];

    @(negedge clk);
    guard = 0;
    while (!up_ready && guard < 1000) begin @(negedge clk); guard++; end
    log_q.delete();
    up_valid = 1'b1; up_write = wr; up_size = sz; up_addr = a; up_wdata = wd;
    @(negedge clk);
    up_valid = 1'b0;
    check(up_ready == 1'b0, "R7", "ready low after accept", {31'b0, up_ready}, 32'h0);
    guard = 0;
    while (!up_done && guard < 1000) begin @(negedge clk); guard++; end
    check(up_done == 1'b1, "R7", "completion seen", {31'b0, up_done}, 32'h1);
    check(up_ready == 1'b1, "R7", "ready back with done", {31'b0, up_ready}, 32'h1);
    if (!wr) check(up_rdata == exp_rd, req, "read data", up_rdata, exp_rd);
    check(log_q.size() == exp_q.size(), "R6", "downstream beat count", log_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < log_q.size(); i++) begin
      check(log_q[i].addr == exp_q[i].addr, "R2", "downstream address", log_q[i].addr, exp_q[i].addr);
      check(log_q[i].wr == exp_q[i].wr && log_q[i].size == exp_q[i].size, "R8", "direction/size",
            {log_q[i].wr, 29'b0, log_q[i].size}, {exp_q[i].wr, 29'b0, exp_q[i].size});
      check(log_q[i].lock == exp_q[i].lock, "R6", "lock level", {31'b0, log_q[i].lock}, {31'b0, exp_q[i].lock});
      if (exp_q[i].wr)
        check(log_q[i].wdata == exp_q[i].wdata, hit ? "R5" : "R8", "write-back data", log_q[i].wdata, exp_q[i].wdata);
    end
    for (int i = 0; i < nb; i++)
      check(mem_rd(baddr + i) == ref_rd(baddr + i), "R5", "backing byte", {24'b0, mem_rd(baddr + i)}, {24'b0, ref_rd(baddr + i)});
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[32'h2000_0000 + i] = 8'(i * 37 + 5);
      mem[32'h4000_0000 + i] = 8'(i * 91 + 3);
    end
    for (int i = 0; i < 4; i++) mem[32'h200F_FFFC + i] = 8'(8'hA5 ^ i);
    foreach (mem[k]) ref_mem[k] = mem[k];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(up_ready && !dn_valid && !dn_lock && !up_done, "R9", "idle after reset",
          {28'b0, up_ready, dn_valid, dn_lock, up_done}, 32'h8);

    // R3 R4 reads of each size
    access(0, 2'd0, 32'h2200_0074, 0, "R4");
    access(0, 2'd1, 32'h2200_0234, 0, "R3");
    access(0, 2'd2, 32'h4200_0100 + 7*4, 0, "R3");
    // R5 set and clear, only bit 0 of data counts
    access(1, 2'd0, 32'h2200_0008, 32'h0000_0001, "R5");
    access(1, 2'd0, 32'h2200_0004, 32'hFFFF_FFFE, "R5");
    access(0, 2'd0, 32'h2200_0004, 0, "R5");
    access(1, 2'd1, 32'h2200_0438, 32'h0000_0003, "R5");
    access(1, 2'd2, 32'h4200_0000 + 31*4, 32'h0, "R5");
    // R1 window edges
    access(0, 2'd0, 32'h23FF_FFFC, 0, "R1");
    access(1, 2'd2, 32'h23FF_FFFC, 32'h1, "R1");
    access(0, 2'd2, 32'h23FF_FFFC, 0, "R1");
    // R8 passthrough, including just outside the windows
    access(1, 2'd2, 32'h2400_0000, 32'hDEAD_BEEF, "R8");
    access(0, 2'd2, 32'h2400_0000, 0, "R8");
    access(1, 2'd1, 32'h21FF_FFFC, 32'h0000_C3A1, "R8");
    access(0, 2'd1, 32'h21FF_FFFC, 0, "R8");
    access(0, 2'd2, 32'h2000_0010, 0, "R8");
    // R2 R3 sweep with varying latency
    for (int k = 0; k < 24; k++) begin
      lat = k % 3;
      access(k[0], 2'(k % 3), 32'h4200_0000 + k * 32'h94, 32'(k >> 1), "R2");
    end

    // R9 reset during locked read phase
    lat = 6;
    @(negedge clk);
    log_q.delete();
    up_valid = 1'b1; up_write = 1'b1; up_size = 2'd0; up_addr = 32'h2200_0000; up_wdata = 32'h1;
    @(negedge clk);
    up_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(up_ready && !dn_valid && !dn_lock, "R9", "idle after mid-flight reset",
          {29'b0, up_ready, dn_valid, dn_lock}, 32'h4);
    repeat (10) @(negedge clk);
    check(log_q.size() == 0, "R9", "no beat after reset", log_q.size(), 0);
    check(mem_rd(32'h2000_0000) == ref_rd(32'h2000_0000), "R9", "backing unchanged",
          {24'b0, mem_rd(32'h2000_0000)}, {24'b0, ref_rd(32'h2000_0000)});
    lat = 1;
    access(0, 2'd0, 32'h2200_0000, 0, "R4");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule